// File: doc/BRIEF.md
# Microprogram Sequencer with Encoded Jump Control

This block steps through a microprogram that controls a bus-based processor. A microprogram counter addresses a control store. Each control word holds a 17-bit vector of datapath strobes, a 3-bit jump code and an absolute target field. On every clock the sequencer chooses the next microaddress from four sources: the counter plus one, the counter itself, the absolute target, or an entry address looked up from the macro-instruction opcode.

Two inputs decide the conditional cases. A memory busy flag makes the sequencer wait on the current word. An ALU zero flag decides the two conditional branches. The control store is read synchronously and addressed with the next microaddress, so the control vector and the microaddress are both registered and always describe the same word. The store contents are computed when the design is elaborated.

Several opcodes share one microroutine, so the store needs only one entry point per group of opcodes. The jump code replaces a full next-address field for most words, which keeps each word narrow.

Top module: `useq_top`

## Requirements
- R1: A synchronous active-high `rst` sets `upc` to 0 on the next rising edge, and `ctrl` then shows the word at address 0.
- R2: Jump code 0, and the unused codes 6 and 7, advance to `upc`+1 modulo 32. Address 31 wraps to 0.
- R3: Jump code 1 keeps `upc` unchanged while `busy` is 1 and advances to `upc`+1 when `busy` is 0.
- R4: Jump code 2 loads the word's target field. Every such word in the store targets address 0.
- R5: Jump code 3 loads the entry address of the opcode's group:
  - opcode 0x00 or 0x08..0x0F go to 4;
  - 0x23 goes to 7;
  - 0x2B goes to 12;
  - 0x04 goes to 17;
  - 0x05 goes to 22;
  - 0x02 goes to 27;
  - any other opcode goes to 30.
- R6: Jump code 4 loads the target (0) when `zero` is 1, and goes to `upc`+1 otherwise.
- R7: Jump code 5 goes to `upc`+1 when `zero` is 1, and loads the target (0) otherwise.
- R8: The fetch routine is laid out as follows:
  - address 0: memory-address load, code 0;
  - address 1: instruction-register load plus memory enable, code 1;
  - address 2: code 0;
  - address 3: code 3.
- R9: The routines are laid out as follows:
  - register ALU at 4..6, with fetch at 6;
  - load at 7..11, with the memory-address load at 9, the memory read plus spin at 10 and fetch at 11;
  - store at 12..16, with the memory-address load at 14, the memory write plus spin at 15 and fetch at 16;
  - branch-if-zero at 17..21, with code 5 at 18 and fetch at 21;
  - branch-if-nonzero at 22..26, with code 4 at 23 and fetch at 26;
  - jump at 27..29, with fetch at 29.
- R10: `ctrl` bit positions are:
  - bit 0: instruction-register load;
  - bit 3: memory-address load;
  - bit 6: memory enable;
  - bit 7: memory write.

  Addresses 30 and 31 carry an all-zero control vector, with code 6 at 30 and code 7 at 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Macro-instruction opcode used by dispatch |
| zero | input | 1 | ALU zero flag |
| busy | input | 1 | Memory busy flag |
| ctrl | output | 17 | Registered datapath control vector |
| upc | output | 5 | Registered current microaddress |

## Verification
Each opcode group is run through a complete instruction with both values of `zero`. This separates the two conditional branch codes from each other and from plain sequencing. Memory busy is held for several cycles in every spin state, which shows that waiting differs from advancing. An opcode outside every group drives the sequencer through the two unused codes and the wrap from 31 to 0. A long phase with random flags and opcodes and occasional resets follows, and checks every step against a behavioural next-address model.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    JT_NEXT  = 3'd0,
    JT_SPIN  = 3'd1,
    JT_FETCH = 3'd2,
    JT_DISP  = 3'd3,
    JT_FEQZ  = 3'd4,
    JT_FNEZ  = 3'd5
  } jump_t;

  // control vector bit positions
  localparam int C_LD_IR  = 0;
  localparam int C_LD_A   = 1;
  localparam int C_LD_B   = 2;
  localparam int C_LD_MA  = 3;
  localparam int C_REG_WR = 4;
  localparam int C_REG_EN = 5;
  localparam int C_MEM_EN = 6;
  localparam int C_MEM_WR = 7;
  localparam int C_ALU_EN = 8;
  localparam int C_IMM_EN = 9;
  localparam int C_OPSEL  = 10; // 2 bits
  localparam int C_EXTSEL = 12; // 2 bits
  localparam int C_REGSEL = 14; // 3 bits
  localparam int CTRL_BITS = 17;

  localparam logic [2:0] RS_RS = 3'd0;
  localparam logic [2:0] RS_RT = 3'd1;
  localparam logic [2:0] RS_RD = 3'd2;
  localparam logic [2:0] RS_PC = 3'd4;
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CTRL_W = CTRL_BITS
) (
  input  logic                             clk,
  input  logic [ADDR_W-1:0]                rd_addr,
  output logic [ADDR_W+3+CTRL_W-1:0]       rd_word
);
  localparam int WORD_W = ADDR_W + 3 + CTRL_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  function automatic logic [WORD_W-1:0] build(input int a);
    logic [CTRL_W-1:0] c;
    logic [2:0]        j;
    c = '0;
    j = JT_NEXT;
    case (a)
      0:  begin c[C_LD_MA] = 1'b1; c[C_REG_EN] = 1'b1; c[C_REGSEL+:3] = RS_PC; end
      1:  begin c[C_LD_IR] = 1'b1; c[C_MEM_EN] = 1'b1; j = JT_SPIN; end
      2:  begin c[C_LD_A] = 1'b1; c[C_REG_EN] = 1'b1; c[C_REGSEL+:3] = RS_PC; end
      3:  begin c[C_ALU_EN] = 1'b1; c[C_OPSEL+:2] = 2'd1; c[C_REG_WR] = 1'b1;
                c[C_REGSEL+:3] = RS_PC; j = JT_DISP; end
      4:  begin c[C_LD_A] = 1'b1; c[C_REG_EN] = 1'b1; c[C_REGSEL+:3] = RS_RS; end
      5:  begin c[C_LD_B] = 1'b1; c[C_REG_EN] = 1'b1; c[C_REGSEL+:3] = RS_RT; end
      6:  begin c[C_ALU_EN] = 1'b1; c[C_REG_WR] = 1'b1; c[C_REGSEL+:3] = RS_RD; j = JT_FETCH; end
      7, 12: begin c[C_LD_A] = 1'b1; c[C_REG_EN] = 1'b1; c[C_REGSEL+:3] = RS_RS; end
      8, 13: begin c[C_LD_B] = 1'b1; c[C_IMM_EN] = 1'b1; end
      9, 14: begin c[C_LD_MA] = 1'b1; c[C_ALU_EN] = 1'b1; end
      10: begin c[C_MEM_EN] = 1'b1; c[C_REG_WR] = 1'b1; c[C_REGSEL+:3] = RS_RT; j = JT_SPIN; end
      15: begin c[C_MEM_EN] = 1'b1; c[C_MEM_WR] = 1'b1; c[C_REG_EN] = 1'b1;
                c[C_REGSEL+:3] = RS_RT; j = JT_SPIN; end
      11, 16: j = JT_FETCH;
      17, 22: begin c[C_LD_A] = 1'b1; c[C_REG_EN] = 1'b1; c[C_REGSEL+:3] = RS_RS; end
      18: j = JT_FNEZ;
      23: j = JT_FEQZ;
      19, 24, 27: begin c[C_LD_A] = 1'b1; c[C_REG_EN] = 1'b1; c[C_REGSEL+:3] = RS_PC; end
      20, 25: begin c[C_LD_B] = 1'b1; c[C_IMM_EN] = 1'b1; c[C_EXTSEL+:2] = 2'd1; end
      28: begin c[C_LD_B] = 1'b1; c[C_IMM_EN] = 1'b1; c[C_EXTSEL+:2] = 2'd2; end
      21, 26, 29: begin c[C_ALU_EN] = 1'b1; c[C_REG_WR] = 1'b1;
                    c[C_REGSEL+:3] = RS_PC; j = JT_FETCH; end
      30: j = 3'd6;
      31: j = 3'd7;
      default: j = JT_NEXT;
    endcase
    // target field is 0 for every word: fetch and both branches return to fetch
    return {{ADDR_W{1'b0}}, j, c};
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = build(i);
  end

  always_ff @(posedge clk) rd_word <= mem[rd_addr];
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
  parameter int OP_W   = 6,
  parameter int ADDR_W = 5
) (
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] entry
);
  localparam logic [ADDR_W-1:0] E_ALU = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] E_LD  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] E_ST  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] E_BZ  = ADDR_W'(17);
  localparam logic [ADDR_W-1:0] E_BNZ = ADDR_W'(22);
  localparam logic [ADDR_W-1:0] E_JMP = ADDR_W'(27);
  localparam logic [ADDR_W-1:0] E_BAD = ADDR_W'(30);

  // group the opcode first, then map the group to one entry word
  always_comb begin
    if (opcode == OP_W'(0) || opcode[OP_W-1:3] == (OP_W-3)'(1)) entry = E_ALU;
    else if (opcode == OP_W'('h23)) entry = E_LD;
    else if (opcode == OP_W'('h2B)) entry = E_ST;
    else if (opcode == OP_W'('h04)) entry = E_BZ;
    else if (opcode == OP_W'('h05)) entry = E_BNZ;
    else if (opcode == OP_W'('h02)) entry = E_JMP;
    else entry = E_BAD;
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [2:0]        jcode,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] entry,
  input  logic              zero,
  input  logic              busy,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] inc;
  assign inc = cur + ADDR_W'(1);

  always_comb begin
    case (jcode)
      JT_SPIN:  nxt = busy ? cur : inc;
      JT_FETCH: nxt = target;
      JT_DISP:  nxt = entry;
      JT_FEQZ:  nxt = zero ? target : inc;
      JT_FNEZ:  nxt = zero ? inc : target;
      default:  nxt = inc;
    endcase
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int OP_W   = 6,
  parameter int CTRL_W = CTRL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic              zero,
  input  logic              busy,
  output logic [CTRL_W-1:0] ctrl,
  output logic [ADDR_W-1:0] upc
);
  localparam int WORD_W = ADDR_W + 3 + CTRL_W;
  localparam logic [ADDR_W-1:0] START = '0;

  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] entry, nxt, rd_addr, target;
  logic [2:0]        jcode;

  assign ctrl   = word[CTRL_W-1:0];
  assign jcode  = word[CTRL_W+:3];
  assign target = word[CTRL_W+3+:ADDR_W];

  useq_dispatch #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_disp (
    .opcode(opcode), .entry(entry)
  );

  useq_next #(.ADDR_W(ADDR_W)) u_next (
    .cur(upc), .jcode(jcode), .target(target), .entry(entry),
    .zero(zero), .busy(busy), .nxt(nxt)
  );

  assign rd_addr = rst ? START : nxt;

  useq_rom #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_rom (
    .clk(clk), .rd_addr(rd_addr), .rd_word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) upc <= START;
    else     upc <= nxt;
  end

  a_r1_reset_start: assert property (@(posedge clk) rst |=> upc == START);
  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (jcode == JT_NEXT || jcode == 3'd6 || jcode == 3'd7) |=> upc == $past(upc) + ADDR_W'(1));
  a_r3_spin_hold: assert property (@(posedge clk) disable iff (rst)
    (jcode == JT_SPIN && busy) |=> $stable(upc));
  a_r4_fetch_target: assert property (@(posedge clk) disable iff (rst)
    (jcode == JT_FETCH) |=> upc == START);
  a_r5_dispatch: assert property (@(posedge clk) disable iff (rst)
    (jcode == JT_DISP) |=> upc == $past(entry));
  a_r6_feqz_taken: assert property (@(posedge clk) disable iff (rst)
    (jcode == JT_FEQZ && zero) |=> upc == START);
  a_r7_fnez_fall: assert property (@(posedge clk) disable iff (rst)
    (jcode == JT_FNEZ && zero) |=> upc == $past(upc) + ADDR_W'(1));
endmodule

// File: tb/sim_useq_top.sv
module sim_useq_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, zero, busy;
  logic [5:0]  opcode;
  logic [16:0] ctrl;
  logic [4:0]  upc;

  useq_top u0 (.clk(clk), .rst(rst), .opcode(opcode), .zero(zero), .busy(busy),
               .ctrl(ctrl), .upc(upc));

  int checks = 0, fails = 0, m_upc = -1, cycles = 0;
  string m_tag = "R1";
  bit done = 0;

  function automatic int exp_jt(int a);
    case (a)
      1, 10, 15: return 1;
      6, 11, 16, 21, 26, 29: return 2;
      3: return 3;
      23: return 4;
      18: return 5;
      30: return 6;
      31: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_entry(logic [5:0] op);
    if (op == 6'h00 || (op >= 6'h08 && op <= 6'h0F)) return 4;
    if (op == 6'h23) return 7;
    if (op == 6'h2B) return 12;
    if (op == 6'h04) return 17;
    if (op == 6'h05) return 22;
    if (op == 6'h02) return 27;
    return 30;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    string t;
    if (m_upc < 0) return;
    chk(upc == 5'(m_upc), m_tag, upc, m_upc);
    t = (m_upc < 4) ? "R8" : (m_upc >= 30) ? "R10" : "R9";
    chk(ctrl[3] == (m_upc == 0 || m_upc == 9 || m_upc == 14), t, ctrl[3], 0);
    chk(ctrl[6] == (m_upc == 1 || m_upc == 10 || m_upc == 15), t, ctrl[6], 0);
    chk(ctrl[7] == (m_upc == 15), t, ctrl[7], 0);
    chk(ctrl[0] == (m_upc == 1), t, ctrl[0], 0);
    if (m_upc >= 30) chk(ctrl == '0, "R10", ctrl, 0);
  endtask

  // called just after a falling edge
  task automatic cyc(bit r, logic [5:0] op, bit z, bit b);
    int nxt;
    string tg;
    check_outputs();
    rst = r; opcode = op; zero = z; busy = b;
    if (r) begin nxt = 0; tg = "R1"; end
    else begin
      case (exp_jt(m_upc))
        1: begin nxt = b ? m_upc : (m_upc + 1) % 32; tg = "R3"; end
        2: begin nxt = 0; tg = "R4"; end
        3: begin nxt = exp_entry(op); tg = "R5"; end
        4: begin nxt = z ? 0 : (m_upc + 1) % 32; tg = "R6"; end
        5: begin nxt = z ? (m_upc + 1) % 32 : 0; tg = "R7"; end
        default: begin nxt = (m_upc + 1) % 32; tg = "R2"; end
      endcase
    end
    @(posedge clk);
    m_upc = nxt; m_tag = tg;
    @(negedge clk);
  endtask

  logic [5:0] ops [9] = '{6'h00, 6'h0A, 6'h23, 6'h2B, 6'h04, 6'h05, 6'h02, 6'h3F, 6'h11};

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; opcode = 0; zero = 0; busy = 0;
    @(negedge clk);
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    // R1: after reset the word at 0 is shown
    chk(upc == 0 && ctrl[3] == 1'b1, "R1", upc, 0);
    // directed: every opcode group with both zero values, busy held in spins
    foreach (ops[k]) begin
      for (int z = 0; z < 2; z++) begin
        int sp = 0;
        for (int n = 0; n < 14; n++) begin
          bit b = (exp_jt(m_upc) == 1) && (sp < 3);
          if (b) sp++; else if (exp_jt(m_upc) != 1) sp = 0;
          cyc(0, ops[k], z[0], b);
        end
      end
    end
    // random phase
    for (int n = 0; n < 4000; n++) begin
      cyc(($urandom % 97) == 0, ops[$urandom % 9], $urandom % 2, ($urandom % 3) != 0);
    end
    check_outputs();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule